// File: doc/BRIEF.md
# Converter serial readout port with sync marker and tag chaining

This block is the digital output side of a 16-bit sampling converter. It keeps the result of the last finished conversion and sends it out on one serial line. The line is clocked by a continuous data clock that the receiver supplies. A qualifying clock edge arms the port. The next edge raises a one-cycle sync marker. The following sixteen edges drive the word, most significant bit first. After the word, the same line passes on a tag input delayed by sixteen clocks. This lets the serial output of another converter be appended, so several converters can share one data line.

The word on the line belongs to the previous conversion, and it can be read while the next conversion is running. A conversion-complete strobe delivers a new straight-binary result in parallel. If the strobe arrives while a word is being sent, the new result is parked and moves in once the word has left. An output-coding select chooses straight binary or two's complement. It is applied when the word enters the shift register. A busy flag marks a conversion in progress.

Top module: `sar_serial_out`

## Requirements
- R1: While rst_ni is low, and after it rises until the port is armed, sync_o and data_o are 0 and busy_o is 1.
- R2: A rising edge (edge #0) arms the port when cs_i is 1, or when cs_i and rc_i are both 0, provided the port is idle or passing tag bits. The port is not armed while a word is being sent. sync_o is 1 only in the cycle after the next edge (edge #1) and is 0 in every other cycle.
- R3: After edges #2 through #17, data_o carries the word from bit 15 down to bit 0, one bit per edge.
- R4: The coding select fmt_i is sampled at edge #1. With fmt_i=1 the stored straight-binary word is sent unchanged. With fmt_i=0 its bit 15 is inverted (two's complement), so midscale 0x8000 is sent as 0x0000.
- R5: data_o is 0 after the arming edge and after edge #1.
- R6: After edge #18+j (j >= 0), data_o equals the tag_i level sampled at edge #2+j. The tag stream ends when the port is armed again.
- R7: A res_vld_i strobe while the port is idle or passing tags updates the stored word at that edge. A strobe at edges #1 through #17 (armed, sync or sending) parks the result. The parked result becomes the stored word at the first edge after edge #17, and the word being sent is not affected.
- R8: A direct strobe at the same edge as a parked transfer wins: the strobed value is stored and the parked one is dropped.
- R9: busy_o falls at an edge where cs_i and rc_i are both 0 while busy_o is 1. It rises at an edge where res_vld_i is 1 while busy_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Continuous data clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, active low |
| rc_i | input | 1 | Read/convert; 0 with cs_i low starts a conversion |
| fmt_i | input | 1 | Output coding: 1 straight binary, 0 two's complement |
| tag_i | input | 1 | Serial input from the next converter in the chain |
| res_i | input | 16 | Straight-binary conversion result |
| res_vld_i | input | 1 | Conversion-complete strobe for res_i |
| data_o | output | 1 | Serial data line |
| sync_o | output | 1 | One-cycle marker before the word |
| busy_o | output | 1 | 0 while a conversion runs |

## Verification
Two events can fall on the same edge: a conversion-complete strobe, and the end of a word or an earlier parked transfer. The bench places strobes at edge #1, edge #5, the last-bit edge #17, and both #17 and #18 together. For each case it judges which value the following readout carries, and that the word already on the line is unchanged. The readouts alternate the arming path and the coding select. Tag patterns are checked bit by bit across the handoff from word to tag stream.

// File: rtl/sar_so_pkg.sv
package sar_so_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_SYNC,
    ST_SHIFT,
    ST_TAG
  } so_state_e;
endpackage

// File: rtl/sar_so_seq.sv
module sar_so_seq
  import sar_so_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  output logic ld_o,
  output logic snd_o,
  output logic tag_sel_o,
  output logic rd_busy_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  so_state_e        st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE:  if (arm_i) st_q <= ST_ARMED;
        ST_ARMED: st_q <= ST_SYNC;
        ST_SYNC: begin
          st_q  <= ST_SHIFT;
          cnt_q <= CNT_W'(1);
        end
        ST_SHIFT: begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == LAST) st_q <= ST_TAG;
        end
        ST_TAG:   if (arm_i) st_q <= ST_ARMED;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign ld_o      = (st_q == ST_ARMED);
  assign snd_o     = (st_q == ST_SYNC) || (st_q == ST_SHIFT);
  assign tag_sel_o = (st_q == ST_TAG);
  assign rd_busy_o = ld_o || snd_o;
endmodule

// File: rtl/sar_so_resbuf.sv
module sar_so_resbuf #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] res_i,
  input  logic              res_vld_i,
  input  logic              rd_busy_i,
  output logic [DATA_W-1:0] word_o
);
  logic [DATA_W-1:0] cur_q, hold_q;
  logic              pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      hold_q <= '0;
      pend_q <= 1'b0;
    end else if (res_vld_i) begin
      if (rd_busy_i) begin
        hold_q <= res_i;
        pend_q <= 1'b1;
      end else begin
        cur_q  <= res_i;
        pend_q <= 1'b0;  // newer result supersedes parked one
      end
    end else if (pend_q && !rd_busy_i) begin
      cur_q  <= hold_q;
      pend_q <= 1'b0;
    end
  end

  assign word_o = cur_q;
endmodule

// File: rtl/sar_so_shreg.sv
module sar_so_shreg #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic              fmt_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              shift_i,
  output logic              msb_o
);
  logic [DATA_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (ld_i) begin
      // fmt_i=0: flip sign bit for two's complement
      sr_q <= {word_i[DATA_W-1] ^ ~fmt_i, word_i[DATA_W-2:0]};
    end else if (shift_i) begin
      sr_q <= {sr_q[DATA_W-2:0], 1'b0};
    end
  end

  assign msb_o = sr_q[DATA_W-1];
endmodule

// File: rtl/sar_so_tagdly.sv
module sar_so_tagdly #(
  parameter int DEPTH = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tag_i,
  output logic tag_o
);
  logic [DEPTH-1:0] dl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dl_q <= '0;
    else         dl_q <= {dl_q[DEPTH-2:0], tag_i};
  end

  assign tag_o = dl_q[DEPTH-1];
endmodule

// File: rtl/sar_so_conv_flag.sv
module sar_so_conv_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic done_i,
  output logic busy_o
);
  logic busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                busy_q <= 1'b1;
    else if (busy_q && start_i) busy_q <= 1'b0;
    else if (!busy_q && done_i) busy_q <= 1'b1;
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/sar_serial_out.sv
module sar_serial_out #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              rc_i,
  input  logic              fmt_i,
  input  logic              tag_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              res_vld_i,
  output logic              data_o,
  output logic              sync_o,
  output logic              busy_o
);
  logic arm, start;
  logic ld, snd, tag_sel, rd_busy;
  logic [DATA_W-1:0] word;
  logic sr_msb, tag_dly;
  logic data_q, sync_q;

  assign arm   = cs_i | ~rc_i;
  assign start = ~cs_i & ~rc_i;

  sar_so_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i, .rst_ni, .arm_i(arm),
    .ld_o(ld), .snd_o(snd), .tag_sel_o(tag_sel), .rd_busy_o(rd_busy)
  );

  sar_so_resbuf #(.DATA_W(DATA_W)) u_resbuf (
    .clk_i, .rst_ni, .res_i, .res_vld_i, .rd_busy_i(rd_busy), .word_o(word)
  );

  sar_so_shreg #(.DATA_W(DATA_W)) u_shreg (
    .clk_i, .rst_ni, .ld_i(ld), .fmt_i, .word_i(word), .shift_i(snd), .msb_o(sr_msb)
  );

  sar_so_tagdly #(.DEPTH(DATA_W)) u_tagdly (
    .clk_i, .rst_ni, .tag_i, .tag_o(tag_dly)
  );

  sar_so_conv_flag u_flag (
    .clk_i, .rst_ni, .start_i(start), .done_i(res_vld_i), .busy_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      sync_q <= ld;
      if (snd)                 data_q <= sr_msb;
      else if (tag_sel && !arm) data_q <= tag_dly;
      else                     data_q <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign sync_o = sync_q;
endmodule

// File: rtl/sar_serial_out_chk.sv
module sar_serial_out_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_i,
  input logic rc_i,
  input logic res_vld_i,
  input logic data_o,
  input logic sync_o,
  input logic busy_o
);
  // R2
  sync_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> !sync_o);

  // R5
  sync_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> !data_o);

  // R9
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(res_vld_i));

  // R9
  busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(!cs_i && !rc_i));
endmodule

bind sar_serial_out sar_serial_out_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .rc_i(rc_i),
  .res_vld_i(res_vld_i), .data_o(data_o), .sync_o(sync_o), .busy_o(busy_o)
);

// File: tb/sar_serial_out_tb.sv
module sar_serial_out_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, rc = 1'b1, fmt = 1'b1, tag = 1'b0, vld = 1'b0;
  logic [15:0] res = '0;
  logic data, sync, busy;
  int n_chk = 0, n_bad = 0;
  logic exp_busy = 1'b1;

  always #2 clk = ~clk;

  sar_serial_out u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .rc_i(rc), .fmt_i(fmt),
    .tag_i(tag), .res_i(res), .res_vld_i(vld),
    .data_o(data), .sync_o(sync), .busy_o(busy)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // One readout, edges #0..#21; loads placed at given edges (-1 = none)
  task automatic readout(input logic via_rc, input logic f, input logic [15:0] exp_word,
                         input logic [19:0] tp,
                         input int l1_at, input logic [15:0] l1_v,
                         input int l2_at, input logic [15:0] l2_v);
    fmt = f;
    for (int e = 0; e < 22; e++) begin
      cs  = (e == 0) && !via_rc;
      rc  = !((e == 0) && via_rc);
      tag = (e >= 2) ? tp[e-2] : 1'b0;
      vld = (e == l1_at) || (e == l2_at);
      res = (e == l2_at) ? l2_v : l1_v;
      if (e == 0 && via_rc && exp_busy) exp_busy = 1'b0;
      else if (vld && !exp_busy) exp_busy = 1'b1;
      @(negedge clk);
      check("R9 busy", {15'd0, busy}, {15'd0, exp_busy});
      if (e < 2) begin
        check("R2 sync", {15'd0, sync}, {15'd0, e == 1});
        check("R5 data quiet", {15'd0, data}, 16'd0);
      end else begin
        check("R2 sync low", {15'd0, sync}, 16'd0);
        if (e <= 17) check((f ? "R3 bit" : "R4 coded bit"), {15'd0, data}, {15'd0, exp_word[17-e]});
        else         check("R6 tag", {15'd0, data}, {15'd0, tp[e-18]});
      end
    end
    vld = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 sync", {15'd0, sync}, 16'd0);
    check("R1 data", {15'd0, data}, 16'd0);
    check("R1 busy", {15'd0, busy}, 16'd1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    vld = 1'b1; res = 16'h8000;   // idle load, R7
    @(negedge clk); vld = 1'b0;
    @(negedge clk);
    check("R1 idle sync", {15'd0, sync}, 16'd0);
    check("R1 idle data", {15'd0, data}, 16'd0);
    check("R9 busy idle", {15'd0, busy}, 16'd1);
  endtask

  task automatic t_straight_midscale;   // R4
    readout(1'b0, 1'b1, 16'h8000, 20'hA5C3F, -1, '0, -1, '0);
  endtask

  task automatic t_twos_midscale;       // R4
    readout(1'b0, 1'b0, 16'h0000, 20'h5A3C1, -1, '0, -1, '0);
  endtask

  task automatic t_load_mid_word;       // R7, R9: conversion via rc path
    readout(1'b1, 1'b0, 16'h0000, 20'hF0F0F, 5, 16'hABCD, -1, '0);
  endtask

  task automatic t_load_collide;        // R7, R8: parked at #17, direct at #18
    readout(1'b0, 1'b1, 16'hABCD, 20'h13579, 17, 16'h1234, 18, 16'h0F0F);
  endtask

  task automatic t_load_last_bit;       // R8 winner sent coded, R7 park at #17
    readout(1'b0, 1'b0, 16'h8F0F, 20'h2468A, 17, 16'h5555, -1, '0);
  endtask

  task automatic t_load_at_sync;        // R7 park at #1
    readout(1'b0, 1'b1, 16'h5555, 20'hFFFFF, 1, 16'h3333, -1, '0);
  endtask

  task automatic t_after_sync_park;     // R7, R9
    readout(1'b1, 1'b0, 16'hB333, 20'h00001, -1, '0, -1, '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_straight_midscale();
    t_twos_midscale();
    t_load_mid_word();
    t_load_collide();
    t_load_last_bit();
    t_load_at_sync();
    t_after_sync_park();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule